// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block turns a 32-bit logical address into a physical address by walking a page table that lives in memory and is split into two levels. Pages are 1 KB, so the low 10 bits of the logical address pass through as the page offset. The 22-bit page number splits in two. Its upper 12 bits pick an entry in the outer table, whose base comes from a root-table base input. That entry names the inner table. The lower 10 bits of the page number pick the entry in that inner table, and this entry holds the frame number.

A client hands in one logical address at a time over a valid/ready request port. The walker then issues its table reads one at a time on a memory read port. That port has a valid/ready request handshake, and each response can take any number of cycles. When the walk ends, the walker gives a one-cycle response. The response carries either the physical address, or a page fault together with the level of the table whose entry was not valid.

Table entries are 4 bytes wide. Bit 0 is the valid flag and bits [31:10] hold a frame number. Bits [9:1] are reserved and the walker does not look at them. An outer entry's frame number, shifted left by 10, is the base address of the inner table.

Top module: `two_level_walker`

## Requirements
- R1: After reset, req_ready is 1, and mem_req_valid and resp_valid are 0.
- R2: The first read of a walk goes to root_base + 4 × vaddr[31:20]. root_base is taken in the cycle the request is accepted, so later changes to it do not affect that walk.
- R3: When the outer entry has bit 0 set, the second read goes to (outer_entry[31:10] << 10) + 4 × vaddr[19:10].
- R4: A walk where both entries have bit 0 set makes exactly two reads. It returns resp_fault = 0 and resp_paddr = {inner_entry[31:10], vaddr[9:0]}, and entry bits [9:1] have no effect on the result.
- R5: An outer entry with bit 0 clear ends the walk after one read. The response has resp_fault = 1, resp_fault_lvl = 0 (outer) and resp_paddr = 0.
- R6: An inner entry with bit 0 clear ends the walk after two reads. The response has resp_fault = 1, resp_fault_lvl = 1 (inner) and resp_paddr = 0.
- R7: While mem_req_valid is 1 and mem_req_ready is 0, the request stays asserted and mem_req_addr does not change.
- R8: After a read is accepted, no further read is issued until mem_rsp_valid arrives, however many cycles that takes.
- R9: req_ready is 0 from the cycle after a request is accepted until the walk ends. A req_valid seen in that window starts no walk and yields no response.
- R10: Each accepted request yields exactly one response, and resp_valid is high for exactly one cycle per response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | PA_W | Byte address of the outer table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | VA_W | Logical address to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | PA_W | Physical address (0 on fault) |
| resp_fault | output | 1 | Walk ended on an invalid entry |
| resp_fault_lvl | output | 1 | Level that failed: 0 outer, 1 inner |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present (one cycle) |
| mem_rsp_data | input | PTE_W | Table entry returned |

## Verification
The bench builds the walker with its default geometry: 32-bit logical and physical addresses, a 10-bit offset, a 12-bit outer index and 32-bit entries. These settings let it reach both ends of every index field (outer index 0x000 and 0xFFF, inner index 0x000 and 0x3FF) and both extreme offsets. It also exercises a second root table and entries whose reserved bits are set. The memory model stalls requests at random and replies after 0 to 4 cycles, with one walk held for 20 cycles, so every wait state is visited. The bench also offers requests while a walk is in progress, to show they are ignored.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OREQ,
    ST_OWAIT,
    ST_IREQ,
    ST_IWAIT
  } walk_state_t;

  typedef enum logic {
    LVL_OUTER = 1'b0,
    LVL_INNER = 1'b1
  } walk_lvl_t;

endpackage

// File: rtl/walk_pte_decode.sv
module walk_pte_decode #(
  parameter int PTE_W   = 32,
  parameter int FRAME_W = 22
) (
  input  logic [PTE_W-1:0]   pte,
  output logic               pte_valid,
  output logic [FRAME_W-1:0] pte_frame
);
  localparam int RSVD_W = PTE_W - FRAME_W - 1;

  assign pte_valid = pte[0];
  assign pte_frame = pte[PTE_W-1 -: FRAME_W];

  generate
    if (RSVD_W > 0) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^pte[RSVD_W:1];
    end
  endgenerate
endmodule

// File: rtl/walk_addr_gen.sv
module walk_addr_gen #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 10,
  parameter int OUT_W = 12,
  parameter int PTE_W = 32
) (
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [PA_W-1:0]       root_base,
  input  logic [VA_W-1:0]       held_vaddr,
  input  logic [PA_W-OFF_W-1:0] frame,
  output logic [PA_W-1:0]       outer_addr,
  output logic [PA_W-1:0]       inner_addr
);
  localparam int IN_W    = VA_W - OFF_W - OUT_W;
  localparam int ENT_SH  = $clog2(PTE_W / 8);
  localparam int FRAME_W = PA_W - OFF_W;

  logic [OUT_W-1:0] outer_idx;
  logic [IN_W-1:0]  inner_idx;
  logic [PA_W-1:0]  outer_off;
  logic [PA_W-1:0]  inner_off;
  logic [PA_W-1:0]  inner_base;

  assign outer_idx  = req_vaddr[VA_W-1 -: OUT_W];
  assign inner_idx  = held_vaddr[OFF_W +: IN_W];
  assign outer_off  = {{(PA_W-OUT_W){1'b0}}, outer_idx} << ENT_SH;
  assign inner_off  = {{(PA_W-IN_W){1'b0}}, inner_idx} << ENT_SH;
  assign inner_base = {frame[FRAME_W-1:0], {OFF_W{1'b0}}};
  assign outer_addr = root_base + outer_off;
  assign inner_addr = inner_base + inner_off;

  logic unused_va;
  assign unused_va = ^{req_vaddr[VA_W-OUT_W-1:0], held_vaddr[VA_W-1 -: OUT_W], held_vaddr[OFF_W-1:0]};
endmodule

// File: rtl/walk_seq.sv
module walk_seq
  import walk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  output logic [VA_W-1:0]       held_vaddr,
  input  logic [PA_W-1:0]       outer_addr,
  input  logic [PA_W-1:0]       inner_addr,
  input  logic                  pte_valid,
  input  logic [PA_W-OFF_W-1:0] pte_frame,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [PA_W-1:0]       mem_req_addr,
  input  logic                  mem_rsp_valid,
  output logic                  resp_valid,
  output logic [PA_W-1:0]       resp_paddr,
  output logic                  resp_fault,
  output logic                  resp_fault_lvl
);
  walk_state_t state;

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_OREQ) || (state == ST_IREQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      held_vaddr     <= '0;
      mem_req_addr   <= '0;
      resp_valid     <= 1'b0;
      resp_paddr     <= '0;
      resp_fault     <= 1'b0;
      resp_fault_lvl <= LVL_OUTER;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            held_vaddr   <= req_vaddr;
            mem_req_addr <= outer_addr;
            state        <= ST_OREQ;
          end
        end
        ST_OREQ: begin
          if (mem_req_ready) state <= ST_OWAIT;
        end
        ST_OWAIT: begin
          if (mem_rsp_valid) begin
            if (!pte_valid) begin
              resp_valid     <= 1'b1;
              resp_fault     <= 1'b1;
              resp_fault_lvl <= LVL_OUTER;
              resp_paddr     <= '0;
              state          <= ST_IDLE;
            end else begin
              mem_req_addr <= inner_addr;
              state        <= ST_IREQ;
            end
          end
        end
        ST_IREQ: begin
          if (mem_req_ready) state <= ST_IWAIT;
        end
        ST_IWAIT: begin
          if (mem_rsp_valid) begin
            resp_valid     <= 1'b1;
            resp_fault_lvl <= LVL_INNER;
            if (!pte_valid) begin
              resp_fault <= 1'b1;
              resp_paddr <= '0;
            end else begin
              resp_fault <= 1'b0;
              resp_paddr <= {pte_frame, held_vaddr[OFF_W-1:0]};
            end
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/two_level_walker.sv
module two_level_walker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 10,
  parameter int OUT_W = 12,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PA_W-1:0]  root_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_fault,
  output logic             resp_fault_lvl,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);
  localparam int FRAME_W = PA_W - OFF_W;

  logic               pte_valid;
  logic [FRAME_W-1:0] pte_frame;
  logic [VA_W-1:0]    held_vaddr;
  logic [PA_W-1:0]    outer_addr;
  logic [PA_W-1:0]    inner_addr;

  walk_pte_decode #(.PTE_W(PTE_W), .FRAME_W(FRAME_W)) u_dec (
    .pte       (mem_rsp_data),
    .pte_valid (pte_valid),
    .pte_frame (pte_frame)
  );

  walk_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .OUT_W(OUT_W), .PTE_W(PTE_W)
  ) u_agen (
    .req_vaddr  (req_vaddr),
    .root_base  (root_base),
    .held_vaddr (held_vaddr),
    .frame      (pte_frame),
    .outer_addr (outer_addr),
    .inner_addr (inner_addr)
  );

  walk_seq #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_seq (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vaddr      (req_vaddr),
    .held_vaddr     (held_vaddr),
    .outer_addr     (outer_addr),
    .inner_addr     (inner_addr),
    .pte_valid      (pte_valid),
    .pte_frame      (pte_frame),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_addr   (mem_req_addr),
    .mem_rsp_valid  (mem_rsp_valid),
    .resp_valid     (resp_valid),
    .resp_paddr     (resp_paddr),
    .resp_fault     (resp_fault),
    .resp_fault_lvl (resp_fault_lvl)
  );
endmodule

// File: rtl/walk_checker.sv
module walk_checker #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            resp_valid,
  input logic            resp_fault,
  input logic            resp_fault_lvl
);
  logic [1:0] rd_cnt;
  logic       waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt  <= '0;
      waiting <= 1'b0;
    end else begin
      if (req_valid && req_ready) rd_cnt <= '0;
      else if (mem_req_valid && mem_req_ready && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
      if (mem_req_valid && mem_req_ready) waiting <= 1'b1;
      else if (mem_rsp_valid) waiting <= 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) $fell(rst) |-> req_ready && !mem_req_valid && !resp_valid);

  assert_two_reads_R4: assert property (@(posedge clk) disable iff (rst)
    resp_valid && !resp_fault |-> rd_cnt == 2'd2);

  assert_outer_fault_one_read_R5: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_fault && !resp_fault_lvl |-> rd_cnt == 2'd1);

  assert_inner_fault_two_reads_R6: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_fault && resp_fault_lvl |-> rd_cnt == 2'd2);

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (rst)
    waiting |-> !mem_req_valid);

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
endmodule

bind two_level_walker walk_checker #(.PA_W(PA_W)) u_walk_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_rsp_valid  (mem_rsp_valid),
  .resp_valid     (resp_valid),
  .resp_fault     (resp_fault),
  .resp_fault_lvl (resp_fault_lvl)
);

// File: tb/test_two_level_walker.sv
`timescale 1ns/1ps
module test_two_level_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic        resp_fault;
  logic        resp_fault_lvl;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  two_level_walker i_two_level_walker (.*);

  int checks = 0;
  int fails  = 0;
  int resp_seen = 0;
  int accepted  = 0;
  int lat_override = -1;

  logic [31:0] mem [int unsigned];
  logic [33:0] exp_q [$];
  logic [31:0] addr_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic put(input logic [31:0] a, input logic [21:0] fr, input logic [8:0] rsvd, input bit v);
    mem[a] = {fr, rsvd, v};
  endtask

  function automatic logic [31:0] mkva(input logic [11:0] oi, input logic [9:0] ii, input logic [9:0] off);
    return {oi, ii, off};
  endfunction

  // memory model: checks each read address against the scoreboard (R2, R3)
  initial begin
    forever begin
      @(negedge clk);
      if (rst) continue;
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        logic [31:0] a;
        int lat;
        a = mem_req_addr;
        if (addr_q.size() == 0)
          chk(1'b0, "R4", "unexpected extra read", a, 32'h0);
        else begin
          logic [31:0] ea;
          ea = addr_q.pop_front();
          chk(a == ea, "R2/R3", "read address", a, ea);
        end
        lat = (lat_override >= 0) ? lat_override : int'($urandom % 5);
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'h0;
        #0.1;
      end
    end
  end

  // monitor: response scoreboard (R4, R5, R6, R10)
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      resp_seen++;
      if (exp_q.size() == 0)
        chk(1'b0, "R10", "response without request", resp_paddr, 32'h0);
      else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        chk(resp_fault == e[33], e[33] ? (e[32] ? "R6" : "R5") : "R4", "fault flag",
            {31'b0, resp_fault}, {31'b0, e[33]});
        if (e[33])
          chk(resp_fault_lvl == e[32], e[32] ? "R6" : "R5", "fault level",
              {31'b0, resp_fault_lvl}, {31'b0, e[32]});
        chk(resp_paddr == e[31:0], e[33] ? "R5/R6" : "R4", "physical address", resp_paddr, e[31:0]);
      end
    end
  end

  // driver: compute expected reads and result, then offer the request
  task automatic translate(input logic [31:0] va, input logic [31:0] root, input bit junk);
    logic [31:0] a1, e1, a2, e2;
    a1 = root + {18'b0, va[31:20], 2'b00};
    e1 = rd(a1);
    addr_q.push_back(a1);
    if (!e1[0]) exp_q.push_back({1'b1, 1'b0, 32'h0});
    else begin
      a2 = {e1[31:10], 10'b0} + {20'b0, va[19:10], 2'b00};
      e2 = rd(a2);
      addr_q.push_back(a2);
      if (!e2[0]) exp_q.push_back({1'b1, 1'b1, 32'h0});
      else exp_q.push_back({1'b0, 1'b0, e2[31:10], va[9:0]});
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    root_base = root;
    accepted++;
    @(negedge clk);
    // R2: root_base changes after acceptance must not matter
    root_base = ~root;
    if (junk) begin
      // R9: requests offered while busy are ignored
      req_vaddr = ~va;
      repeat (2) begin
        chk(req_ready == 1'b0, "R9", "req_ready while busy", {31'b0, req_ready}, 32'h0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || !req_ready) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] ROOT0 = 32'h0004_0000;
  localparam logic [31:0] ROOT1 = 32'h0010_0000;

  initial begin
    // outer table at ROOT0
    put(ROOT0 + 32'h0,          22'h000200, 9'h0,   1'b1);
    put(ROOT0 + 32'hFFF * 4,    22'h000300, 9'h0,   1'b1);
    put(ROOT0 + 32'h7 * 4,      22'h000340, 9'h0,   1'b1);
    put(ROOT0 + 32'h9 * 4,      22'h000200, 9'h1FF, 1'b0);
    // outer table at ROOT1
    put(ROOT1 + 32'h0,          22'h000300, 9'h0,   1'b1);
    // inner table at 0x80000
    put(32'h0008_0000,          22'h012345, 9'h0,   1'b1);
    put(32'h0008_0000 + 32'h3FF * 4, 22'h03ABCD, 9'h0, 1'b1);
    put(32'h0008_0000 + 32'h155 * 4, 22'h000777, 9'h1FF, 1'b1);
    put(32'h0008_0000 + 32'h2 * 4,   22'h001111, 9'h0,  1'b0);
    // inner table at 0xC0000
    put(32'h000C_0000,          22'h02AAAA, 9'h0,   1'b1);
    put(32'h000C_0000 + 32'h3FF * 4, 22'h015555, 9'h0, 1'b1);

    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", {31'b0, req_ready}, 32'h1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", {31'b0, mem_req_valid}, 32'h0);
    chk(resp_valid == 1'b0, "R1", "resp_valid after reset", {31'b0, resp_valid}, 32'h0);

    // R2 R3 R4: index and offset extremes
    translate(mkva(12'h000, 10'h000, 10'h000), ROOT0, 1'b0);
    translate(mkva(12'h000, 10'h3FF, 10'h3FF), ROOT0, 1'b0);
    translate(mkva(12'hFFF, 10'h000, 10'h2A5), ROOT0, 1'b0);
    translate(mkva(12'hFFF, 10'h3FF, 10'h001), ROOT0, 1'b0);
    // R4: reserved bits set in the inner entry have no effect
    translate(mkva(12'h000, 10'h155, 10'h155), ROOT0, 1'b0);
    // R5: outer invalid, both unpopulated and with a frame field present
    translate(mkva(12'h005, 10'h010, 10'h020), ROOT0, 1'b0);
    translate(mkva(12'h009, 10'h000, 10'h020), ROOT0, 1'b0);
    // R6: inner invalid
    translate(mkva(12'h007, 10'h001, 10'h3C0), ROOT0, 1'b0);
    translate(mkva(12'h000, 10'h002, 10'h0F0), ROOT0, 1'b0);
    // R2: second root table
    translate(mkva(12'h000, 10'h3FF, 10'h111), ROOT1, 1'b0);
    drain();

    // R9: requests while busy are ignored
    translate(mkva(12'h000, 10'h000, 10'h3AB), ROOT0, 1'b1);
    drain();
    translate(mkva(12'hFFF, 10'h000, 10'h0C3), ROOT0, 1'b1);
    drain();

    // R8: a slow memory is waited for
    lat_override = 20;
    translate(mkva(12'hFFF, 10'h3FF, 10'h2FE), ROOT0, 1'b0);
    drain();
    lat_override = -1;

    // R10: back-to-back mixed walks
    for (int k = 0; k < 12; k++) begin
      logic [11:0] oi;
      logic [9:0]  ii;
      case (k % 4)
        0: begin oi = 12'h000; ii = 10'h3FF; end
        1: begin oi = 12'h005; ii = 10'h000; end
        2: begin oi = 12'hFFF; ii = 10'h000; end
        default: begin oi = 12'h007; ii = 10'h004; end
      endcase
      translate(mkva(oi, ii, 10'($urandom)), ROOT0, 1'b0);
    end
    drain();

    chk(resp_seen == accepted, "R10", "responses vs accepted requests", resp_seen, accepted);
    chk(exp_q.size() == 0, "R10", "pending expected responses", exp_q.size(), 0);
    chk(addr_q.size() == 0, "R4", "reads not issued", addr_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule